// File: doc/BRIEF.md
# External Access Strobe Stretcher

This block times one external data-memory access at a time. When a request is accepted it drives an active-low read or write strobe and holds it for a number of machine cycles set by a 3-bit stretch code. Slow memories or peripherals can then be reached without external wait-state logic. When the strobe returns high, a one-clock completion pulse is given.

Machine-cycle boundaries arrive as a single-clock tick. All lengths are counted in those ticks. A request marked as on-chip bypasses the stretch and completes in the base length of two machine cycles. It never drives either external strobe. The stretch code and direction are captured when the request is accepted, so changing them during an access does nothing.

Top module: `xmem_strobe_ctrl`

## Requirements
- R1: After reset, `rd_n` and `wr_n` are 1 and `busy` and `done` are 0.
- R2: For an external access with stretch code S (0 to 7), the selected strobe stays low for exactly S+2 machine-cycle periods, which is (S+2) tick intervals in clocks.
- R3: `busy` rises in the clock after `start` is accepted. The selected strobe goes low at the first tick after acceptance, and a tick in the same clock as `start` does not count. From acceptance to completion the block consumes exactly S+3 ticks: one to open the strobe and S+2 to time it.
- R4: `is_write`=1 selects `wr_n` and `is_write`=0 selects `rd_n`; the other strobe stays at 1, and both are never low together.
- R5: An access with `on_chip`=1 never drives either strobe low. It completes after exactly 2 machine cycles (3 ticks consumed) whatever the stretch code.
- R6: `done` is a one-clock pulse in the clock where the strobe returns high and `busy` falls.
- R7: A `start` while `busy`=1 is ignored and no further access follows.
- R8: Stretch code, direction and on-chip flag are sampled when `start` is accepted. A change during the access changes neither its length nor its strobe.
- R9: The timing of R2 and R5 also holds when a tick arrives in every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | One-clock marker of a machine-cycle boundary |
| start | input | 1 | Request a new access (taken only when idle) |
| is_write | input | 1 | 1 = write access, 0 = read access |
| on_chip | input | 1 | 1 = access to on-chip SRAM, stretch bypassed |
| stretch_sel | input | 3 | Stretch code S; length is S+2 machine cycles |
| rd_n | output | 1 | Active-low external read strobe |
| wr_n | output | 1 | Active-low external write strobe |
| done | output | 1 | One-clock completion pulse |
| busy | output | 1 | High from acceptance until completion |

## Verification
The bench builds the block with its defaults: a 3-bit stretch code and a base length of two machine cycles. This makes every code from 0 to 7 reachable, so both the shortest and longest external lengths are covered. The tick spacing belongs to the bench. With four clocks per machine cycle, an error of one tick or one clock in strobe width can be told apart. A second run with a tick in every clock exercises back-to-back boundaries, where the opening tick and the counting ticks are adjacent.

// File: rtl/xstr_pkg.sv
package xstr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_ACT  = 2'd2
    } xstr_phase_e;

endpackage

// File: rtl/xstr_len_sel.sv
module xstr_len_sel #(
    parameter int STRETCH_W   = 3,
    parameter int BASE_CYCLES = 2,
    parameter int LEN_W       = 4
) (
    input  logic [STRETCH_W-1:0] stretch,
    input  logic                 on_chip,
    output logic [LEN_W-1:0]     len
);

    localparam logic [LEN_W-1:0] BASE_LEN = LEN_W'(BASE_CYCLES);

    always_comb begin
        if (on_chip) begin
            len = BASE_LEN;
        end else begin
            len = LEN_W'(stretch) + BASE_LEN;
        end
    end

endmodule

// File: rtl/xstr_seq.sv
module xstr_seq
    import xstr_pkg::*;
#(
    parameter int LEN_W   = 4,
    parameter int DEF_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_tick,
    input  logic             start,
    input  logic             is_write,
    input  logic             on_chip,
    input  logic [LEN_W-1:0] len_in,
    output logic             rd_n,
    output logic             wr_n,
    output logic             done,
    output logic             busy
);

    typedef struct packed {
        xstr_phase_e      ph;
        logic [LEN_W-1:0] remain;
        logic             wr;
        logic             oc;
        logic             rd_n;
        logic             wr_n;
        logic             done;
        logic             busy;
    } seq_st_t;

    localparam seq_st_t RST_ST = '{
        ph:     PH_IDLE,
        remain: LEN_W'(DEF_LEN),
        wr:     1'b0,
        oc:     1'b0,
        rd_n:   1'b1,
        wr_n:   1'b1,
        done:   1'b0,
        busy:   1'b0
    };

    seq_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph     = PH_WAIT;
                    s_d.remain = len_in;
                    s_d.wr     = is_write;
                    s_d.oc     = on_chip;
                    s_d.busy   = 1'b1;
                end
            end
            PH_WAIT: begin
                if (mc_tick) begin
                    s_d.ph = PH_ACT;
                    if (!s_q.oc) begin
                        s_d.rd_n = s_q.wr;
                        s_d.wr_n = !s_q.wr;
                    end
                end
            end
            PH_ACT: begin
                if (mc_tick) begin
                    if (s_q.remain <= LEN_W'(1)) begin
                        s_d.ph   = PH_IDLE;
                        s_d.rd_n = 1'b1;
                        s_d.wr_n = 1'b1;
                        s_d.done = 1'b1;
                        s_d.busy = 1'b0;
                    end else begin
                        s_d.remain = s_q.remain - LEN_W'(1);
                    end
                end
            end
            default: s_d = RST_ST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= RST_ST;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_n = s_q.rd_n;
    assign wr_n = s_q.wr_n;
    assign done = s_q.done;
    assign busy = s_q.busy;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R4

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> busy); // R3

    AST_ONCHIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && s_q.oc) |-> (rd_n && wr_n)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && rd_n && wr_n)); // R6

    AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(s_q.wr) && $stable(s_q.oc))); // R8

    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R3

endmodule

// File: rtl/xmem_strobe_ctrl.sv
module xmem_strobe_ctrl #(
    parameter int STRETCH_W       = 3,
    parameter int BASE_CYCLES     = 2,
    parameter int DEFAULT_STRETCH = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mc_tick,
    input  logic                 start,
    input  logic                 is_write,
    input  logic                 on_chip,
    input  logic [STRETCH_W-1:0] stretch_sel,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 done,
    output logic                 busy
);

    localparam int MAX_LEN = (1 << STRETCH_W) - 1 + BASE_CYCLES;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int DEF_LEN = DEFAULT_STRETCH + BASE_CYCLES;

    logic [LEN_W-1:0] acc_len;

    xstr_len_sel #(
        .STRETCH_W   (STRETCH_W),
        .BASE_CYCLES (BASE_CYCLES),
        .LEN_W       (LEN_W)
    ) i_len_sel (
        .stretch (stretch_sel),
        .on_chip (on_chip),
        .len     (acc_len)
    );

    xstr_seq #(
        .LEN_W   (LEN_W),
        .DEF_LEN (DEF_LEN)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mc_tick  (mc_tick),
        .start    (start),
        .is_write (is_write),
        .on_chip  (on_chip),
        .len_in   (acc_len),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .done     (done),
        .busy     (busy)
    );

endmodule

// File: tb/test_xmem_strobe_ctrl.sv
module test_xmem_strobe_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic       start = 1'b0;
    logic       is_write = 1'b0;
    logic       on_chip = 1'b0;
    logic [2:0] stretch_sel = 3'd1;
    logic       rd_n, wr_n, done, busy;

    int n_chk = 0;
    int n_err = 0;
    int tick_div = 4;
    int tcnt = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    xmem_strobe_ctrl i_xmem_strobe_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mc_tick     (mc_tick),
        .start       (start),
        .is_write    (is_write),
        .on_chip     (on_chip),
        .stretch_sel (stretch_sel),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .done        (done),
        .busy        (busy)
    );

    always @(posedge clk) begin
        if (tcnt >= tick_div - 1) begin
            mc_tick <= 1'b1;
            tcnt    <= 0;
        end else begin
            mc_tick <= 1'b0;
            tcnt    <= tcnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    task automatic run_access(input bit wr, input bit oc, input logic [2:0] st,
                              input bit disturb, input string req);
        int  len = oc ? 2 : int'(st) + 2;
        int  rdl = 0, wrl = 0, both = 0, ticks = 0, g = 0;
        bit  first = 1'b1, exp_low = 1'b0, seen = 1'b0, hi_at_done = 1'b0;
        bit  busy_at_done = 1'b1, busy_after_start = 1'b0, strobe_ok = 1'b1;
        @(negedge clk);
        is_write = wr; on_chip = oc; stretch_sel = st; start = 1'b1;
        while (!seen && g < 2000) begin
            @(negedge clk);
            g++;
            start = 1'b0;
            if (g == 1) busy_after_start = busy;
            if (exp_low) begin
                strobe_ok = wr ? (!wr_n && rd_n) : (!rd_n && wr_n);
                exp_low = 1'b0;
            end
            if (!rd_n) rdl++;
            if (!wr_n) wrl++;
            if (!rd_n && !wr_n) both++;
            if (done) begin
                seen = 1'b1;
                busy_at_done = busy;
                hi_at_done = rd_n && wr_n;
            end else if (busy && mc_tick) begin
                ticks++;
                if (first) begin
                    first = 1'b0;
                    exp_low = !oc;
                end
            end
            if (disturb && g == 6) begin
                stretch_sel = ~st; is_write = ~wr; on_chip = ~oc; start = 1'b1;
            end
        end
        chk(seen, {req, " done seen"}, int'(seen), 1);
        chk(busy_after_start, "R3 busy after start", int'(busy_after_start), 1);
        chk(ticks == len + 1, {req, " R3 ticks consumed"}, ticks, len + 1);
        if (oc) begin
            chk(rdl == 0 && wrl == 0, "R5 on-chip strobes quiet", rdl + wrl, 0);
        end else begin
            chk(strobe_ok, "R3 strobe falls at first tick", int'(strobe_ok), 1);
            chk((wr ? wrl : rdl) == len * tick_div, {req, " R2 strobe width"},
                wr ? wrl : rdl, len * tick_div);
            chk((wr ? rdl : wrl) == 0, "R4 other strobe idle", wr ? rdl : wrl, 0);
        end
        chk(both == 0, "R4 never both low", both, 0);
        chk(!busy_at_done && hi_at_done, "R6 done with busy low and strobes high",
            int'(busy_at_done), 0);
        @(negedge clk);
        chk(!done, "R6 done one clock", int'(done), 0);
        repeat (3 * tick_div + 4) @(negedge clk);
        chk(!busy && rd_n && wr_n, {req, " R7 no follow-on access"}, int'(busy), 0);
    endtask

    task automatic t_reset();
        chk(rd_n && wr_n, "R1 strobes high in reset", int'({rd_n, wr_n}), 3);
        chk(!busy && !done, "R1 busy/done low in reset", int'({busy, done}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(rd_n && wr_n && !busy && !done, "R1 idle after reset",
            int'({rd_n, wr_n, busy, done}), 12);
    endtask

    task automatic t_all_stretch();
        for (int s = 0; s < 8; s++) begin
            run_access(1'b0, 1'b0, 3'(s), 1'b0, "R2 read");
            run_access(1'b1, 1'b0, 3'(s), 1'b0, "R2 write");
        end
    endtask

    task automatic t_onchip();
        run_access(1'b0, 1'b1, 3'd7, 1'b0, "R5 onchip read s7");
        run_access(1'b1, 1'b1, 3'd0, 1'b0, "R5 onchip write s0");
    endtask

    task automatic t_busy_ignore();
        run_access(1'b0, 1'b0, 3'd5, 1'b1, "R7 R8 restart ignored");
        run_access(1'b1, 1'b0, 3'd0, 1'b1, "R7 R8 restart ignored short");
        run_access(1'b0, 1'b1, 3'd2, 1'b1, "R8 onchip restart ignored");
    endtask

    task automatic t_fast_tick();
        tick_div = 1;
        repeat (3) @(negedge clk);
        run_access(1'b0, 1'b0, 3'd0, 1'b0, "R9 fast read s0");
        run_access(1'b1, 1'b0, 3'd7, 1'b0, "R9 fast write s7");
        run_access(1'b0, 1'b1, 3'd4, 1'b0, "R9 fast onchip");
        tick_div = 4;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_all_stretch();
        t_onchip();
        t_busy_ignore();
        t_fast_tick();
        run_access(1'b1, 1'b0, 3'd3, 1'b0, "R2 write after fast");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule